// File: doc/BRIEF.md
# Auto-Incrementing Channel Word Access Controller

This block is the transaction layer between a two-wire serial byte receiver and a bank of double-buffered DAC staging registers. The byte receiver reports bus events: START or repeated START, STOP, a matched device address with its read/write bit, each received data byte, and each request for a byte to transmit. The controller turns these events into acknowledge decisions, staging-register write strobes, reset commands and read data bytes. Bus timing, filtering and address matching stay in the receiver.

In a write transaction the first data byte selects a channel and may carry a reset command in its top three bits. The bytes that follow come in pairs, most significant byte first. Each pair forms one word for the current channel, and the pointer then moves to the next channel. A register is changed only when both bytes of its word have arrived. A read transaction returns the staging contents as byte pairs with the same auto-increment. The pointer is kept from one transaction to the next, so a read can follow a separate pointer write.

Every event is answered one clock later on registered outputs. Each output strobe lasts one cycle.

Top module: `chan_word_access`

## Requirements
- R1: After reset all strobes and valid outputs are low and the pointer is channel 0, so a read with no pointer write starts at channel 0.
- R2: The first data byte of a write transaction is acknowledged only when its low five bits are below NCH (0x00 to 0x07 by default) and its bits 7:5 are 000, 100 or 010. Any other value is not acknowledged. Every later byte of that transaction is then not acknowledged and produces no strobe.
- R3: A word is an MSB byte followed by an LSB byte, and both are acknowledged. One cycle after the LSB, stg_we_o pulses with stg_ch_o set to the current channel and stg_data_o set to {MSB[1:0], LSB}. In the same cycle stg_latch_o carries MSB bit 7.
- R4: A START or STOP that arrives after an MSB and before its LSB discards the MSB. No strobe follows, and the pointer does not advance.
- R5: After each complete word the pointer moves up by one channel. A pointer byte of 0x00 followed by 16 data bytes writes channels 0 to 7 in order.
- R6: Once the pointer has passed the last channel, write bytes are not acknowledged and produce no strobe, and read bytes return 0x00.
- R7: A pointer byte with bits 7:5 = 100 is acknowledged. One cycle after it, rst_all_o pulses, and the pointer takes the byte's channel field.
- R8: A pointer byte with bits 7:5 = 010 makes the next complete word pulse rst_one_o with rst_one_ch_o set to that word's channel, in place of a write strobe. Later words in the same transaction write normally.
- R9: In a read transaction each channel returns two bytes. The MSB byte has bits 7:2 zero and bits 1:0 equal to value[9:8]. The LSB byte is value[7:0]. The pointer advances after the LSB.
- R10: The pointer value is kept across STOP and START, so a read transaction continues from the last pointer position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start_i | input | 1 | START or repeated START seen |
| bus_stop_i | input | 1 | STOP seen |
| addr_vld_i | input | 1 | Device address matched |
| addr_rnw_i | input | 1 | Read/write bit of the matched address (1 = read) |
| wb_vld_i | input | 1 | Write data byte received |
| wb_data_i | input | 8 | Received data byte |
| rd_req_i | input | 1 | Receiver needs the next read byte |
| stg_q_i | input | NCH*DW | Staging register contents, channel 0 in the low bits |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| rd_vld_o | output | 1 | Read byte valid |
| rd_data_o | output | 8 | Read byte |
| stg_we_o | output | 1 | Staging register write strobe |
| stg_ch_o | output | $clog2(NCH) | Channel written |
| stg_data_o | output | DW | Word value written |
| stg_latch_o | output | 1 | Software-latch flag (MSB bit 7) of the written word |
| rst_all_o | output | 1 | Reset all channels to mid-scale |
| rst_one_o | output | 1 | Reset one channel to mid-scale |
| rst_one_ch_o | output | $clog2(NCH) | Channel to reset |

## Verification
Each test sequence is chosen so that one kind of fault shows up on its own:
- A single word with the latch flag set, which exposes swapped or misplaced bits in the MSB/LSB packing.
- A STOP between the two bytes of a word, which shows whether a half word is committed or the pointer moves when it should not.
- A full 16-byte burst that runs on past the last channel, which checks the auto-increment order and the refusal of bytes beyond the end.
- Read bursts that cross the end and reads with no pointer write, which show whether the pointer persists and whether the MSB byte is masked.
- Bad pointer bytes and the two reset command codes, which separate all-channel resets, single-word resets and refused commands.

// File: rtl/chan_word_access.sv
module chan_word_access #(
  parameter int NCH = 8,
  parameter int DW  = 10,
  parameter int BW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_start_i,
  input  logic                    bus_stop_i,
  input  logic                    addr_vld_i,
  input  logic                    addr_rnw_i,
  input  logic                    wb_vld_i,
  input  logic [BW-1:0]           wb_data_i,
  input  logic                    rd_req_i,
  input  logic [NCH*DW-1:0]       stg_q_i,
  output logic                    ack_vld_o,
  output logic                    ack_o,
  output logic                    rd_vld_o,
  output logic [BW-1:0]           rd_data_o,
  output logic                    stg_we_o,
  output logic [$clog2(NCH)-1:0]  stg_ch_o,
  output logic [DW-1:0]           stg_data_o,
  output logic                    stg_latch_o,
  output logic                    rst_all_o,
  output logic                    rst_one_o,
  output logic [$clog2(NCH)-1:0]  rst_one_ch_o
);

  localparam int PW = $clog2(NCH);
  localparam int CW = $clog2(NCH + 1);
  localparam int HB = DW - BW;

  typedef enum logic [2:0] {W_IDLE, W_PTR, W_HI, W_LO, W_DEAD} wst_t;

  wst_t          wst;
  logic [CW-1:0] ptr;
  logic          rd_mode, rd_lo, one_pend, hold_lat;
  logic [HB-1:0] hold_hi;

  wire [4:0]    pf       = wb_data_i[4:0];
  wire [2:0]    cmd      = wb_data_i[7:5];
  wire          cmd_ok   = (cmd == 3'b000) || (cmd == 3'b100) || (cmd == 3'b010);
  wire          ptr_ok   = (pf < 5'(NCH)) && cmd_ok;
  wire          abort    = bus_start_i | bus_stop_i;
  wire          wb_go    = wb_vld_i & ~abort & ~addr_vld_i & ~rd_mode;
  wire          rd_go    = rd_req_i & ~abort & ~addr_vld_i & rd_mode;
  wire          in_range = ptr < CW'(NCH);
  wire [PW-1:0] pidx     = ptr[PW-1:0];
  wire [DW-1:0] cur      = stg_q_i[pidx*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst          <= W_IDLE;
      ptr          <= '0;
      rd_mode      <= 1'b0;
      rd_lo        <= 1'b0;
      one_pend     <= 1'b0;
      hold_lat     <= 1'b0;
      hold_hi      <= '0;
      ack_vld_o    <= 1'b0;
      ack_o        <= 1'b0;
      rd_vld_o     <= 1'b0;
      rd_data_o    <= '0;
      stg_we_o     <= 1'b0;
      stg_ch_o     <= '0;
      stg_data_o   <= '0;
      stg_latch_o  <= 1'b0;
      rst_all_o    <= 1'b0;
      rst_one_o    <= 1'b0;
      rst_one_ch_o <= '0;
    end else begin
      ack_vld_o <= 1'b0;
      rd_vld_o  <= 1'b0;
      stg_we_o  <= 1'b0;
      rst_all_o <= 1'b0;
      rst_one_o <= 1'b0;
      if (abort) begin
        wst      <= W_IDLE;
        rd_mode  <= 1'b0;
        rd_lo    <= 1'b0;
        one_pend <= 1'b0;
      end else if (addr_vld_i) begin
        rd_mode  <= addr_rnw_i;
        rd_lo    <= 1'b0;
        one_pend <= 1'b0;
        wst      <= addr_rnw_i ? W_IDLE : W_PTR;
      end else if (wb_go) begin
        ack_vld_o <= 1'b1;
        unique case (wst)
          W_PTR: begin
            ack_o <= ptr_ok;
            if (ptr_ok) begin
              ptr       <= CW'(pf);
              rst_all_o <= (cmd == 3'b100);
              one_pend  <= (cmd == 3'b010);
              wst       <= W_HI;
            end else begin
              wst <= W_DEAD;
            end
          end
          W_HI: begin
            ack_o    <= in_range;
            hold_hi  <= wb_data_i[HB-1:0];
            hold_lat <= wb_data_i[BW-1];
            wst      <= in_range ? W_LO : W_DEAD;
          end
          W_LO: begin
            ack_o <= 1'b1;
            ptr   <= ptr + 1'b1;
            wst   <= W_HI;
            if (one_pend) begin
              rst_one_o    <= 1'b1;
              rst_one_ch_o <= pidx;
              one_pend     <= 1'b0;
            end else begin
              stg_we_o    <= 1'b1;
              stg_ch_o    <= pidx;
              stg_data_o  <= {hold_hi, wb_data_i};
              stg_latch_o <= hold_lat;
            end
          end
          default: ack_o <= 1'b0;
        endcase
      end else if (rd_go) begin
        rd_vld_o <= 1'b1;
        rd_lo    <= ~rd_lo;
        if (!in_range)
          rd_data_o <= '0;
        else if (!rd_lo)
          rd_data_o <= BW'(cur[DW-1:BW]);
        else begin
          rd_data_o <= cur[BW-1:0];
          ptr       <= ptr + 1'b1;
        end
      end
    end
  end

  a_r3_we_acked: assert property (@(posedge clk) disable iff (!rst_n)
    stg_we_o |-> (ack_vld_o && ack_o));

  a_r8_one_acked: assert property (@(posedge clk) disable iff (!rst_n)
    rst_one_o |-> (ack_vld_o && ack_o && !stg_we_o));

  a_r7_all_acked: assert property (@(posedge clk) disable iff (!rst_n)
    rst_all_o |-> (ack_vld_o && ack_o && !stg_we_o && !rst_one_o));

  a_r4_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start_i || bus_stop_i) |=> (!stg_we_o && !rst_one_o && !ack_vld_o && !rd_vld_o));

  a_r9_rd_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> $past(rd_req_i));

  a_r2_ack_or_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_vld_o && rd_vld_o));

endmodule

// File: tb/sim_chan_word_access.sv
`timescale 1ns/1ps
module sim_chan_word_access;
  localparam int NCH = 8;
  localparam int DW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start_i = 0, bus_stop_i = 0, addr_vld_i = 0, addr_rnw_i = 0;
  logic wb_vld_i = 0, rd_req_i = 0;
  logic [7:0] wb_data_i = '0;
  logic [NCH*DW-1:0] stg_q_i;
  logic ack_vld_o, ack_o, rd_vld_o, stg_we_o, stg_latch_o, rst_all_o, rst_one_o;
  logic [7:0] rd_data_o;
  logic [2:0] stg_ch_o, rst_one_ch_o;
  logic [DW-1:0] stg_data_o;

  always #4 clk = ~clk;

  chan_word_access #(.NCH(NCH), .DW(DW), .BW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_start_i(bus_start_i), .bus_stop_i(bus_stop_i),
    .addr_vld_i(addr_vld_i), .addr_rnw_i(addr_rnw_i), .wb_vld_i(wb_vld_i),
    .wb_data_i(wb_data_i), .rd_req_i(rd_req_i), .stg_q_i(stg_q_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o),
    .stg_we_o(stg_we_o), .stg_ch_o(stg_ch_o), .stg_data_o(stg_data_o),
    .stg_latch_o(stg_latch_o), .rst_all_o(rst_all_o), .rst_one_o(rst_one_o),
    .rst_one_ch_o(rst_one_ch_o));

  logic [DW-1:0] mstg [NCH];
  int mptr;
  int checks = 0, failures = 0;
  bit done = 0, running = 0;
  logic [27:0] exq[$];
  string tq[$];

  always_comb
    for (int i = 0; i < NCH; i++) stg_q_i[i*DW +: DW] = mstg[i];

  localparam logic [3:0] K_ACK = 4'd1, K_WE = 4'd2, K_RA = 4'd3, K_RO = 4'd4, K_RD = 4'd5;

  task automatic push(input logic [3:0] k, input logic [23:0] d, input string tag);
    exq.push_back({k, d});
    tq.push_back(tag);
  endtask

  task automatic observe(input logic [27:0] got);
    logic [27:0] e;
    string t;
    checks++;
    if (exq.size() == 0) begin
      failures++;
      $display("FAIL unexpected event actual=%h expected=none", got);
    end else begin
      e = exq.pop_front();
      t = tq.pop_front();
      if (e !== got) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, got, e);
      end
    end
  endtask

  always @(negedge clk) if (running) begin
    if (ack_vld_o) observe({K_ACK, 23'd0, ack_o});
    if (stg_we_o)  observe({K_WE, 9'd0, stg_latch_o, 1'b0, stg_ch_o, stg_data_o});
    if (rst_all_o) observe({K_RA, 24'd0});
    if (rst_one_o) observe({K_RO, 21'd0, rst_one_ch_o});
    if (rd_vld_o)  observe({K_RD, 16'd0, rd_data_o});
  end

  task automatic t_start(); bus_start_i = 1; @(negedge clk); bus_start_i = 0; endtask
  task automatic t_stop();  bus_stop_i = 1;  @(negedge clk); bus_stop_i = 0;  endtask
  task automatic t_addr(input logic rnw);
    addr_vld_i = 1; addr_rnw_i = rnw; @(negedge clk); addr_vld_i = 0; addr_rnw_i = 0;
  endtask
  task automatic t_wb(input logic [7:0] b);
    wb_vld_i = 1; wb_data_i = b; @(negedge clk); wb_vld_i = 0; wb_data_i = '0;
  endtask
  task automatic t_rd(); rd_req_i = 1; @(negedge clk); rd_req_i = 0; endtask

  task automatic pbyte(input logic [7:0] b, input string tag);
    push(K_ACK, 24'd1, tag);
    mptr = int'(b[4:0]);
    if (b[7:5] == 3'b100) begin
      push(K_RA, 24'd0, tag);
      for (int i = 0; i < NCH; i++) mstg[i] = 10'h200;
    end
    t_wb(b);
  endtask

  task automatic wr_word(input logic [7:0] msb, input logic [7:0] lsb, input string tag);
    logic [DW-1:0] v;
    v = {msb[1:0], lsb};
    push(K_ACK, 24'd1, tag);
    t_wb(msb);
    push(K_ACK, 24'd1, tag);
    push(K_WE, {9'd0, msb[7], 1'b0, 3'(mptr), v}, tag);
    mstg[mptr] = v;
    mptr++;
    t_wb(lsb);
  endtask

  task automatic rd_word(input string tag);
    if (mptr < NCH) begin
      push(K_RD, {22'd0, mstg[mptr][9:8]}, tag);
      t_rd();
      push(K_RD, {16'd0, mstg[mptr][7:0]}, tag);
      t_rd();
      mptr++;
    end else begin
      push(K_RD, 24'd0, tag);
      t_rd();
      push(K_RD, 24'd0, tag);
      t_rd();
    end
  endtask

  task automatic nack_byte(input logic [7:0] b, input string tag);
    push(K_ACK, 24'd0, tag);
    t_wb(b);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) mstg[i] = 10'(10'h2C3 + i * 71);
    mptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at the ports
    checks++;
    if ({ack_vld_o, rd_vld_o, stg_we_o, rst_all_o, rst_one_o} !== 5'b0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b expected=00000",
               {ack_vld_o, rd_vld_o, stg_we_o, rst_all_o, rst_one_o});
    end
    running = 1;

    // R1 R10: read with no pointer write starts at channel 0
    t_start(); t_addr(1); rd_word("R1 read from ch0 after reset"); t_stop();

    // R3: single word with latch flag
    t_start(); t_addr(0); pbyte(8'h03, "R3 pointer");
    wr_word(8'h81, 8'h5A, "R3 word commit"); t_stop();

    // R4: abort after MSB, pointer stays
    t_start(); t_addr(0); pbyte(8'h05, "R4 pointer");
    push(K_ACK, 24'd1, "R4 msb ack"); t_wb(8'h02); t_stop();
    t_start(); t_addr(1); rd_word("R4 R10 unchanged ch5"); t_stop();

    // R5 R6: full burst then past end
    t_start(); t_addr(0); pbyte(8'h00, "R5 pointer");
    for (int i = 0; i < NCH; i++)
      wr_word((i == 7) ? 8'h80 | 8'(i % 4) : 8'(i % 4), 8'(8'h11 * i + 3), "R5 burst word");
    nack_byte(8'h01, "R6 write past end msb");
    nack_byte(8'h22, "R6 write past end lsb");
    t_stop();
    t_start(); t_addr(1); rd_word("R6 R10 read past end"); t_stop();

    // R9: read burst across the end
    t_start(); t_addr(0); pbyte(8'h06, "R9 pointer");
    t_start(); t_addr(1);
    rd_word("R9 read ch6"); rd_word("R9 read ch7"); rd_word("R6 read beyond ch7");
    t_stop();

    // R2: refused pointer bytes
    t_start(); t_addr(0); nack_byte(8'h08, "R2 pointer out of range");
    nack_byte(8'h01, "R2 byte after refused pointer"); t_stop();
    t_start(); t_addr(0); nack_byte(8'h63, "R2 command 011"); t_stop();
    t_start(); t_addr(0); nack_byte(8'hE1, "R2 command 111"); t_stop();
    t_start(); t_addr(1); rd_word("R2 pointer untouched"); t_stop();

    // R7: reset all then write
    t_start(); t_addr(0); pbyte(8'h82, "R7 reset all");
    wr_word(8'h03, 8'hFF, "R7 word after reset"); t_stop();
    t_start(); t_addr(0); pbyte(8'h01, "R7 pointer");
    t_start(); t_addr(1); rd_word("R7 mid-scale ch1"); rd_word("R7 written ch2"); t_stop();

    // R8: reset single channel by next word
    t_start(); t_addr(0); pbyte(8'h44, "R8 pointer");
    push(K_ACK, 24'd1, "R8 msb ack"); t_wb(8'h03);
    push(K_ACK, 24'd1, "R8 lsb ack"); push(K_RO, 24'd4, "R8 reset ch4");
    mstg[4] = 10'h200; mptr = 5;
    t_wb(8'h77);
    wr_word(8'h01, 8'h10, "R8 next word normal"); t_stop();
    t_start(); t_addr(0); pbyte(8'h04, "R8 pointer read");
    t_start(); t_addr(1); rd_word("R8 ch4 mid-scale"); rd_word("R8 ch5 written"); t_stop();

    repeat (4) @(negedge clk);
    checks++;
    if (exq.size() != 0) begin
      failures++;
      $display("FAIL R3 missing events actual=%0d expected=0", exq.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule